// File: doc/BRIEF.md
# Configurable SPI Bus Master

This block is the controlling end of a four-wire synchronous serial link. It generates the serial clock, drives the outgoing data line and samples the incoming data line. It also owns a bank of active-low device-select lines. Every transfer is full duplex: while one character goes out, one character of the same length comes in.

Each start request carries its own settings. These are the clock polarity, the clock phase, the character length, which device to select, and a divisor that sets the half-period of the serial clock in system-clock cycles. The block latches all of them when it accepts the start. It returns the received character with a one-cycle completion pulse.

A controller places the outgoing word right-aligned on `tx_word`, chooses the settings and raises `start` while `busy` is low. It then waits for `done`, at which point `rx_word` holds the character that came back.

Top module: `spi_xfer_master`

## Requirements
- R1: While reset is held, and just after it ends, every select line is high, `busy` and `done` are low, and `mosi` and `sclk` are low.
- R2: Outside a transfer, `sclk` follows the `cpol` input with one cycle of delay, so the idle clock level equals the chosen polarity.
- R3: A start accepted while idle raises `busy` in the next cycle. Select line `ss_n[i]` with i equal to the latched `ss_idx` is then low, and every other line is high, for the whole transfer up to the completion cycle.
- R4: For an effective length N and divisor D, `sclk` toggles exactly 2N times. The first toggle comes D+1 cycles after acceptance, and each further toggle comes D+1 cycles after the one before.
- R5: With `cpha`=0, the first bit is on `mosi` before the first clock edge, `miso` is sampled on leading edges and `mosi` changes on trailing edges. With `cpha`=1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. A leading edge is one that moves `sclk` away from `cpol`.
- R6: Bits go out most significant first. `mosi` carries `tx_word[N-1:0]` from bit N-1 down to bit 0. `rx_word` returns the N sampled bits right-aligned, the first sampled bit at position N-1, with all bits above N-1 at zero.
- R7: The effective length N is `char_len` clamped to the range 4 to 16. Values below 4 act as 4, and values above 16 act as 16.
- R8: `done` is a one-cycle pulse that rises (2N+1)(D+1) cycles after acceptance. In that same cycle all select lines are high and `busy` is low. `rx_word` holds its value until the next completion.
- R9: A start raised while `busy` is high is ignored. The select lines, the timing and the result of the running transfer do not change, and no extra completion follows.
- R10: A start raised in the cycle where `done` is high is accepted, so a new transfer begins with no idle gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a transfer (taken only when idle) |
| cpol | input | 1 | Clock polarity (idle level of sclk) |
| cpha | input | 1 | Clock phase: 0 samples on leading edge, 1 on trailing edge |
| char_len | input | 5 | Requested character length in bits |
| ss_idx | input | 2 | Index of the device select line to drive |
| clk_div | input | 8 | Half-period of sclk minus one, in clk cycles |
| tx_word | input | 16 | Outgoing character, right-aligned |
| miso | input | 1 | Serial data from the selected device |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | 16 | Received character, right-aligned |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the devices |
| ss_n | output | 4 | Active-low device select lines |

## Verification
Two events can fall in the same cycle: the completion of one transfer and the acceptance of the next start. The bench provokes this by raising `start` with a new device index in exactly the cycle where `done` is seen high. It then checks that the next cycle already shows `busy` high with only the new select line low. It also checks that the second character completes at its own expected time with correct data in both directions. A second collision, a start landing in the middle of a running transfer, is judged by the select lines staying constant, the completion time and data of the running transfer, and the absence of any further completion.

// File: rtl/spi_xfer_pkg.sv
package spi_xfer_pkg;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SHIFT = 2'd1,
      PH_TAIL  = 2'd2
   } xfer_phase_e;

   // limit a requested character length to the supported window
   function automatic int clamp_len(input int raw, input int lo, input int hi);
      if (raw < lo) return lo;
      if (raw > hi) return hi;
      return raw;
   endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic             past_valid;

   assign tick = run && (cnt == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         past_valid <= 1'b0;
      end else begin
         past_valid <= 1'b1;
         if (!run || tick) cnt <= '0;
         else              cnt <= cnt + DIV_W'(1);
      end
   end

   // R4
   tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && run && tick && (div != '0)) |=> !tick);

endmodule

// File: rtl/spi_sel_decode.sv
module spi_sel_decode #(
   parameter int NUM_SS = 4,
   parameter int SS_W   = 2
) (
   input  logic              active,
   input  logic [SS_W-1:0]   idx,
   output logic [NUM_SS-1:0] ss_n
);

   for (genvar i = 0; i < NUM_SS; i++) begin : g_line
      assign ss_n[i] = !(active && (int'(idx) == i));
   end

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
   parameter int MAX_BITS = 16,
   parameter int LEN_W    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                late_phase,
   input  logic [LEN_W-1:0]    len_in,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                launch,
   input  logic                sample,
   input  logic                finish,
   input  logic                miso,
   output logic                mosi,
   output logic [MAX_BITS-1:0] rx_word
);

   logic [MAX_BITS-1:0] tx_sr;
   logic [MAX_BITS-1:0] rx_sr;
   logic [MAX_BITS-1:0] aligned;
   logic                past_valid;

   // move the character so its top bit sits at the shift-out end
   assign aligned = tx_word << (MAX_BITS - int'(len_in));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_sr      <= '0;
         rx_sr      <= '0;
         mosi       <= 1'b0;
         rx_word    <= '0;
         past_valid <= 1'b0;
      end else begin
         past_valid <= 1'b1;
         if (load) begin
            rx_sr <= '0;
            if (late_phase) begin
               tx_sr <= aligned;
               mosi  <= 1'b0;
            end else begin
               tx_sr <= {aligned[MAX_BITS-2:0], 1'b0};
               mosi  <= aligned[MAX_BITS-1];
            end
         end else begin
            if (launch) begin
               mosi  <= tx_sr[MAX_BITS-1];
               tx_sr <= {tx_sr[MAX_BITS-2:0], 1'b0};
            end
            if (sample) rx_sr <= {rx_sr[MAX_BITS-2:0], miso};
            if (finish) begin
               rx_word <= rx_sr;
               mosi    <= 1'b0;
            end
         end
      end
   end

   // R8
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !finish) |=> $stable(rx_word));

endmodule

// File: rtl/spi_xfer_master.sv
module spi_xfer_master #(
   parameter int MIN_BITS = 4,
   parameter int MAX_BITS = 16,
   parameter int NUM_SS   = 4,
   parameter int DIV_W    = 8,
   localparam int LEN_W   = $clog2(MAX_BITS + 1),
   localparam int SS_W    = (NUM_SS > 1) ? $clog2(NUM_SS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cpol,
   input  logic                cpha,
   input  logic [LEN_W-1:0]    char_len,
   input  logic [SS_W-1:0]     ss_idx,
   input  logic [DIV_W-1:0]    clk_div,
   input  logic [MAX_BITS-1:0] tx_word,
   input  logic                miso,
   output logic                busy,
   output logic                done,
   output logic [MAX_BITS-1:0] rx_word,
   output logic                sclk,
   output logic                mosi,
   output logic [NUM_SS-1:0]   ss_n
);
   import spi_xfer_pkg::*;

   localparam int EC_W = LEN_W + 1;

   if (MIN_BITS < 2 || MAX_BITS < MIN_BITS) begin : g_bad_len
      $error("character length window is invalid");
   end
   if (NUM_SS < 1 || DIV_W < 1) begin : g_bad_cfg
      $error("select count and divisor width must be positive");
   end

   xfer_phase_e      phase;
   logic             cpol_q;
   logic             cpha_q;
   logic [LEN_W-1:0] len_q;
   logic [SS_W-1:0]  idx_q;
   logic [DIV_W-1:0] div_q;
   logic [EC_W-1:0]  ecnt;
   logic [EC_W-1:0]  last_edge;
   logic [LEN_W-1:0] len_eff;
   logic             accept;
   logic             tick;
   logic             edge_tick;
   logic             leading;
   logic             sample_en;
   logic             launch_en;
   logic             finish;
   logic             done_q;
   logic             past_valid;

   assign len_eff   = LEN_W'(clamp_len(int'(char_len), MIN_BITS, MAX_BITS));
   assign accept    = start && (phase == PH_IDLE);
   assign last_edge = {len_q, 1'b0} - EC_W'(1);
   assign edge_tick = tick && (phase == PH_SHIFT);
   assign leading   = !ecnt[0];
   assign sample_en = edge_tick && (leading ^ cpha_q);
   assign launch_en = edge_tick && !(leading ^ cpha_q);
   assign finish    = tick && (phase == PH_TAIL);
   assign busy      = (phase != PH_IDLE);
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase      <= PH_IDLE;
         cpol_q     <= 1'b0;
         cpha_q     <= 1'b0;
         len_q      <= LEN_W'(MIN_BITS);
         idx_q      <= '0;
         div_q      <= '0;
         ecnt       <= '0;
         sclk       <= 1'b0;
         done_q     <= 1'b0;
         past_valid <= 1'b0;
      end else begin
         past_valid <= 1'b1;
         done_q     <= finish;
         unique case (phase)
            PH_IDLE: begin
               sclk <= cpol;
               if (accept) begin
                  phase  <= PH_SHIFT;
                  cpol_q <= cpol;
                  cpha_q <= cpha;
                  len_q  <= len_eff;
                  idx_q  <= ss_idx;
                  div_q  <= clk_div;
                  ecnt   <= '0;
               end
            end
            PH_SHIFT: begin
               if (tick) begin
                  sclk <= ~sclk;
                  if (ecnt == last_edge) phase <= PH_TAIL;
                  else                   ecnt  <= ecnt + EC_W'(1);
               end
            end
            PH_TAIL: begin
               if (tick) phase <= PH_IDLE;
            end
            default: phase <= PH_IDLE;
         endcase
      end
   end

   spi_half_timer #(.DIV_W(DIV_W)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div   (div_q),
      .tick  (tick)
   );

   spi_shift_engine #(.MAX_BITS(MAX_BITS), .LEN_W(LEN_W)) u_engine (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .late_phase (cpha),
      .len_in     (len_eff),
      .tx_word    (tx_word),
      .launch     (launch_en),
      .sample     (sample_en),
      .finish     (finish),
      .miso       (miso),
      .mosi       (mosi),
      .rx_word    (rx_word)
   );

   spi_sel_decode #(.NUM_SS(NUM_SS), .SS_W(SS_W)) u_sel (
      .active (busy),
      .idx    (idx_q),
      .ss_n   (ss_n)
   );

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8
   done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ((&ss_n) && !busy));

   // R9
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && busy && $past(busy)) |-> $stable(ss_n));

   // R2
   idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && !busy && $past(!busy)) |-> (sclk == $past(cpol)));

   // R4
   sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $past(phase == PH_SHIFT) && !$past(tick)) |-> $stable(sclk));

   // R3
   sel_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> ($countones(~ss_n) <= 1));

endmodule

// File: tb/spi_xfer_master_tb.sv
module spi_xfer_master_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cpol = 1'b0;
   logic        cpha = 1'b0;
   logic [4:0]  char_len = 5'd8;
   logic [1:0]  ss_idx = 2'd0;
   logic [7:0]  clk_div = 8'd0;
   logic [15:0] tx_word = 16'h0;
   logic        miso = 1'b0;
   logic        busy;
   logic        done;
   logic [15:0] rx_word;
   logic        sclk;
   logic        mosi;
   logic [3:0]  ss_n;

   int nchk = 0;
   int nfail = 0;

   always #2 clk = ~clk;

   spi_xfer_master u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cpol(cpol), .cpha(cpha),
      .char_len(char_len), .ss_idx(ss_idx), .clk_div(clk_div), .tx_word(tx_word),
      .miso(miso), .busy(busy), .done(done), .rx_word(rx_word), .sclk(sclk),
      .mosi(mosi), .ss_n(ss_n)
   );

   // behavioural device on the far end of the link
   logic        b_pol = 1'b0;
   logic        b_ph = 1'b0;
   int          b_len = 8;
   logic [15:0] s_tx = 16'h0;
   logic [15:0] s_rx = 16'h0;
   int          oi = 0;
   int          toggles = 0;
   logic        sel_any;
   logic        p_sel = 1'b0;
   logic        p_sclk = 1'b0;

   assign sel_any = ~&ss_n;

   always @(sclk or sel_any) begin
      if (sel_any === 1'b1 && p_sel !== 1'b1) begin
         s_rx = 16'h0;
         oi = 0;
         miso = b_ph ? 1'b0 : s_tx[b_len-1];
      end else if (sel_any === 1'b1 && sclk !== p_sclk) begin
         toggles++;
         if ((sclk != b_pol) ^ b_ph) s_rx = {s_rx[14:0], mosi};
         else if (b_ph) begin
            if (oi < b_len) miso = s_tx[b_len-1-oi];
            oi++;
         end else begin
            oi++;
            if (oi < b_len) miso = s_tx[b_len-1-oi];
         end
      end
      p_sel = sel_any;
      p_sclk = sclk;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int eff_len(input int l);
      return (l < 4) ? 4 : ((l > 16) ? 16 : l);
   endfunction

   task automatic launch(input logic pol, input logic ph, input logic [4:0] len,
                         input logic [1:0] idx, input logic [7:0] dv,
                         input logic [15:0] tx, input logic [15:0] stx);
      @(negedge clk);
      cpol = pol; cpha = ph; char_len = len; ss_idx = idx; clk_div = dv; tx_word = tx;
      b_pol = pol; b_ph = ph; b_len = eff_len(int'(len)); s_tx = stx; toggles = 0;
      @(negedge clk);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   // returns at the negedge where done is seen high
   task automatic await_done(input logic [1:0] idx, input int inject,
                             output int cyc, output int ss_bad);
      cyc = 0;
      ss_bad = 0;
      forever begin
         @(posedge clk);
         cyc++;
         @(negedge clk);
         if (cyc == inject) begin
            start = 1'b1;
            ss_idx = ~idx;
            tx_word = 16'hFFFF;
         end else start = 1'b0;
         if (done) break;
         if (ss_n !== ~(4'b0001 << idx)) ss_bad++;
         if (cyc > 20000) break;
      end
      start = 1'b0;
   endtask

   task automatic verify(input int n, input int dv, input logic [15:0] tx,
                         input logic [15:0] stx, input int cyc, input int ss_bad);
      logic [15:0] m;
      m = 16'((32'h1 << n) - 1);
      chk(cyc == (2*n+1)*(dv+1), "R8", "done latency", cyc, (2*n+1)*(dv+1));
      chk(rx_word == (stx & m), "R6", "received word", rx_word, stx & m);
      chk((s_rx & m) == (tx & m), "R5", "bits seen by device", s_rx & m, tx & m);
      chk(toggles == 2*n, "R4", "sclk toggle count", toggles, 2*n);
      chk(ss_bad == 0, "R3", "select pattern during transfer", ss_bad, 0);
      chk((ss_n == 4'hF) && !busy, "R8", "release at done", {busy, ss_n}, 5'h0F);
   endtask

   // cpol, cpha, len[5], idx[2], div[8], tx[16], device tx[16]
   localparam logic [48:0] VEC [0:7] = '{
      {1'b0, 1'b0, 5'd8,  2'd0, 8'd0, 16'h00A5, 16'h003C},
      {1'b0, 1'b1, 5'd8,  2'd1, 8'd1, 16'h005A, 16'h00C3},
      {1'b1, 1'b0, 5'd12, 2'd2, 8'd2, 16'h0ABC, 16'h0123},
      {1'b1, 1'b1, 5'd16, 2'd3, 8'd0, 16'hBEEF, 16'h1234},
      {1'b0, 1'b0, 5'd4,  2'd1, 8'd3, 16'h0009, 16'h0006},
      {1'b1, 1'b1, 5'd4,  2'd0, 8'd1, 16'h0003, 16'h000C},
      {1'b0, 1'b1, 5'd16, 2'd2, 8'd2, 16'h8001, 16'h7FFE},
      {1'b1, 1'b0, 5'd7,  2'd3, 8'd0, 16'h0055, 16'h002A}
   };

   initial begin
      repeat (150000) @(posedge clk);
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      int cyc;
      int sb;
      int n;
      int extra;
      // R1 reset state
      repeat (3) @(negedge clk);
      chk((ss_n == 4'hF) && !busy && !done && !mosi && !sclk, "R1", "outputs in reset",
          {ss_n, busy, done, mosi, sclk}, 8'hF0);
      rst_n = 1'b1;
      @(negedge clk);
      chk((ss_n == 4'hF) && !busy && !done && !mosi && !sclk, "R1", "outputs after reset",
          {ss_n, busy, done, mosi, sclk}, 8'hF0);

      // R2 idle level follows polarity
      cpol = 1'b1;
      @(negedge clk);
      chk(sclk == 1'b1, "R2", "idle sclk with cpol=1", sclk, 1);
      cpol = 1'b0;
      @(negedge clk);
      chk(sclk == 1'b0, "R2", "idle sclk with cpol=0", sclk, 0);

      // table of mode/length/select/rate combinations (R3 R4 R5 R6 R8)
      for (int i = 0; i < 8; i++) begin
         launch(VEC[i][48], VEC[i][47], VEC[i][46:42], VEC[i][41:40], VEC[i][39:32],
                VEC[i][31:16], VEC[i][15:0]);
         chk(busy && (ss_n == ~(4'b0001 << VEC[i][41:40])), "R3", "busy and select after start",
             {busy, ss_n}, {1'b1, ~(4'b0001 << VEC[i][41:40])});
         await_done(VEC[i][41:40], -1, cyc, sb);
         verify(eff_len(int'(VEC[i][46:42])), int'(VEC[i][39:32]), VEC[i][31:16],
                VEC[i][15:0], cyc, sb);
         @(negedge clk);
         chk(sclk == VEC[i][48], "R2", "idle level after transfer", sclk, VEC[i][48]);
      end

      // R7 short length clamps to 4
      launch(1'b0, 1'b0, 5'd2, 2'd1, 8'd1, 16'h00F3, 16'h00F5);
      await_done(2'd1, -1, cyc, sb);
      verify(4, 1, 16'h00F3, 16'h00F5, cyc, sb);
      chk(cyc == 9*2, "R7", "latency of clamped short length", cyc, 18);

      // R7 long length clamps to 16
      launch(1'b1, 1'b1, 5'd25, 2'd2, 8'd0, 16'hC3A5, 16'h5A3C);
      await_done(2'd2, -1, cyc, sb);
      verify(16, 0, 16'hC3A5, 16'h5A3C, cyc, sb);
      chk(cyc == 33, "R7", "latency of clamped long length", cyc, 33);

      // R9 start while busy is ignored
      launch(1'b0, 1'b1, 5'd8, 2'd0, 8'd1, 16'h0096, 16'h0069);
      await_done(2'd0, 5, cyc, sb);
      verify(8, 1, 16'h0096, 16'h0069, cyc, sb);
      extra = 0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (done || busy) extra++;
      end
      chk(extra == 0, "R9", "no second transfer after ignored start", extra, 0);

      // R10 start in the completion cycle
      launch(1'b1, 1'b0, 5'd6, 2'd1, 8'd1, 16'h002D, 16'h0012);
      await_done(2'd1, -1, cyc, sb);
      verify(6, 1, 16'h002D, 16'h0012, cyc, sb);
      start = 1'b1; ss_idx = 2'd3; char_len = 5'd5; tx_word = 16'h0015;
      b_len = 5; s_tx = 16'h000A; toggles = 0;
      @(negedge clk);
      start = 1'b0;
      chk(busy && (ss_n == 4'b0111), "R10", "back-to-back start accepted",
          {busy, ss_n}, 5'h17);
      await_done(2'd3, -1, cyc, sb);
      n = 5;
      verify(n, 1, 16'h0015, 16'h000A, cyc, sb);

      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule